// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a synchronous Moore state machine for a gum-style vending unit with one coin slot. A coin sensor delivers one-cycle strobes, one for a nickel and one for a dime. The block adds up the deposited credit. When the credit reaches the price of 15 cents, it raises an open signal to the release mechanism for exactly one clock cycle. It then drops back to zero credit.

The credit is held as a small binary-coded state: zero, one, two or three five-cent units. Overpayment is absorbed: a dime at 10 cents dispenses just as a nickel would, and no change is given. A nickel and a dime on the same cycle cannot happen in normal use, so that pair is mapped to "no coin". The open output comes from a flop and never depends on the coin inputs in the same cycle.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces zero credit and drives `openOut` low in the following cycle. Coin strobes present during reset are discarded.
- R2: Outside the 15-cent state, a nickel strobe alone (`nickelPulse`=1, `dimePulse`=0) adds 5 cents and a dime strobe alone adds 10 cents, while the sum stays below 15 cents.
- R3: When a coin would bring the credit to 15 cents or more, the credit saturates at 15 cents and the excess is dropped. From 10 cents, a nickel or a dime both lead to the 15-cent state.
- R4: `openOut` is high exactly in the cycle after the clock edge that moves the machine into the 15-cent state, and low in every other cycle.
- R5: Both strobes high in the same cycle are treated as no coin, and the credit is unchanged.
- R6: The 15-cent state lasts one cycle and always returns to zero credit, so each purchase yields one single-cycle open pulse.
- R7: Coin strobes sampled while in the 15-cent state are ignored; the machine still returns to zero credit.
- R8: The credit state uses a 2-bit binary code: 00 is 0 cents, 01 is 5 cents, 10 is 10 cents and 11 is 15 cents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickelPulse | input | 1 | One-cycle strobe: a 5-cent coin was sensed |
| dimePulse | input | 1 | One-cycle strobe: a 10-cent coin was sensed |
| openOut | output | 1 | Registered release pulse, high for one cycle per purchase |

## Verification
A coin sampled at a rising edge changes the credit at that same edge. If that edge completes the price, `openOut` is high from just after that edge until the next edge, so the open pulse is due one cycle after the strobe is presented. The bench drives the strobes at falling edges and compares `openOut` at the following falling edge against a credit model kept in the bench. Every check therefore falls exactly half a cycle after the edge that should produce the result. An exhaustive sweep of all four-cycle coin patterns, each started from reset, covers every order of coins that reaches or passes 15 cents, as well as the strobes that arrive during the dispense cycle.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

  typedef enum logic [1:0] {
    COIN_NONE   = 2'd0,
    COIN_NICKEL = 2'd1,
    COIN_DIME   = 2'd2
  } coinKind_t;

  typedef struct packed {
    logic enterFull;
  } ctrlStrobes_t;

endpackage

// File: rtl/coin_vend_dp.sv
module coin_vend_dp
  import coin_vend_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         nickelIn,
  input  logic         dimeIn,
  input  ctrlStrobes_t strobes,
  output coinKind_t    coinKind,
  output logic         openQ
);

  // a simultaneous pair is not a legal coin event: decode to none
  always_comb begin
    unique case ({dimeIn, nickelIn})
      2'b01:   coinKind = COIN_NICKEL;
      2'b10:   coinKind = COIN_DIME;
      default: coinKind = COIN_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) openQ <= 1'b0;
    else     openQ <= strobes.enterFull;
  end

  // R6: the release pulse never lasts more than one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    openQ |=> !openQ);

  // R4: open follows entry into the full state by one edge
  a_r4_open_on_entry: assert property (@(posedge clk) disable iff (rst)
    strobes.enterFull |=> openQ);

  a_r4_open_quiet: assert property (@(posedge clk) disable iff (rst)
    !strobes.enterFull |=> !openQ);

endmodule

// File: rtl/coin_vend_fsm.sv
module coin_vend_fsm
  import coin_vend_pkg::*;
#(
  parameter int PRICE_UNITS  = 3,
  parameter int NICKEL_UNITS = 1,
  parameter int DIME_UNITS   = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  coinKind_t    coinKind,
  output ctrlStrobes_t strobes
);

  localparam int CW = $clog2(PRICE_UNITS + 1);
  localparam int SW = CW + 1;
  localparam logic [CW-1:0] FULL = CW'(PRICE_UNITS);

  // R8: binary credit code, 0..PRICE_UNITS five-cent units
  logic [CW-1:0] credit;
  logic [CW-1:0] creditNext;
  logic [SW-1:0] addUnits;
  logic [SW-1:0] sum;
  logic          full;
  logic          reaches;

  assign full = (credit == FULL);

  always_comb begin
    unique case (coinKind)
      COIN_NICKEL: addUnits = SW'(NICKEL_UNITS);
      COIN_DIME:   addUnits = SW'(DIME_UNITS);
      default:     addUnits = '0;
    endcase
  end

  assign sum     = {1'b0, credit} + addUnits;
  assign reaches = !full && (sum >= SW'(PRICE_UNITS));

  always_comb begin
    if (full)         creditNext = '0;
    else if (reaches) creditNext = FULL;
    else              creditNext = sum[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) credit <= '0;
    else     credit <= creditNext;
  end

  assign strobes.enterFull = reaches;

  // R1: reset lands in the zero-credit state regardless of coins
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> credit == '0);

  // R6 / R7: the full state always returns to zero, whatever coin arrives
  a_r6_full_to_idle: assert property (@(posedge clk) disable iff (rst)
    full |=> credit == '0);

  // R5: no coin (including the simultaneous pair) holds the credit
  a_r5_no_coin_holds: assert property (@(posedge clk) disable iff (rst)
    (!full && coinKind == COIN_NONE) |=> $stable(credit));

  // R2: a coin below the price adds its value
  a_r2_adds_value: assert property (@(posedge clk) disable iff (rst)
    (!full && coinKind != COIN_NONE && !reaches)
      |=> credit == $past(sum[CW-1:0]));

  // R3: reaching or passing the price saturates at full
  a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
    reaches |=> full);

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import coin_vend_pkg::*;
#(
  parameter int PRICE_UNITS  = 3,
  parameter int NICKEL_UNITS = 1,
  parameter int DIME_UNITS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nickelPulse,
  input  logic dimePulse,
  output logic openOut
);

  coinKind_t    coinKind;
  ctrlStrobes_t strobes;

  coin_vend_fsm #(
    .PRICE_UNITS (PRICE_UNITS),
    .NICKEL_UNITS(NICKEL_UNITS),
    .DIME_UNITS  (DIME_UNITS)
  ) fsm_i (
    .clk     (clk),
    .rst     (rst),
    .coinKind(coinKind),
    .strobes (strobes)
  );

  coin_vend_dp dp_i (
    .clk     (clk),
    .rst     (rst),
    .nickelIn(nickelPulse),
    .dimeIn  (dimePulse),
    .strobes (strobes),
    .coinKind(coinKind),
    .openQ   (openOut)
  );

endmodule

// File: tb/coin_vend_ctrl_tb_top.sv
module coin_vend_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickelPulse = 1'b0;
  logic dimePulse = 1'b0;
  logic openOut;

  int checks = 0;
  int fails  = 0;
  int mCredit = 0;        // model credit in 5-cent units
  string pendTag = "R1";

  always #4 clk = ~clk;   // 125 MHz

  coin_vend_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .nickelPulse(nickelPulse),
    .dimePulse  (dimePulse),
    .openOut    (openOut)
  );

  task automatic checkOpen(input string tag, input logic expV);
    checks++;
    if (openOut !== expV) begin
      fails++;
      $display("FAIL %s openOut actual=%b expected=%b at %0t", tag, openOut, expV, $time);
    end
  endtask

  // called at a falling edge: check the result of the last edge, then drive the next inputs
  task automatic step(input logic rv, input logic nv, input logic dv);
    int add;
    int nxt;
    @(negedge clk);
    checkOpen(pendTag, mCredit == 3);
    rst = rv; nickelPulse = nv; dimePulse = dv;
    add = (nv && !dv) ? 1 : ((dv && !nv) ? 2 : 0);
    if (rv) begin
      nxt = 0; pendTag = "R1";
    end else if (mCredit == 3) begin
      nxt = 0; pendTag = (nv || dv) ? "R7" : "R6";
    end else if (nv && dv) begin
      nxt = mCredit; pendTag = "R5";
    end else if (mCredit + add > 3) begin
      nxt = 3; pendTag = "R3";
    end else if (mCredit + add == 3) begin
      nxt = 3; pendTag = "R4";
    end else begin
      nxt = mCredit + add; pendTag = "R2";
    end
    mCredit = nxt;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset with a dime present
    rst = 1'b1; dimePulse = 1'b1;
    @(negedge clk);
    mCredit = 0; pendTag = "R1";
    step(1'b1, 1'b0, 1'b1);
    // exhaustive: every 4-cycle pattern over {none, nickel, dime, both}
    for (int seq = 0; seq < 256; seq++) begin
      step(1'b1, seq[0], seq[1]);       // R1: reset, with coins discarded
      for (int k = 0; k < 4; k++) begin
        logic [1:0] c;
        c = 2'((seq >> (2 * k)) & 3);
        step(1'b0, c[0], c[1]);
      end
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
    end
    // R7: a dime during dispense must not pre-load credit
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);             // reaches 15
    step(1'b0, 1'b0, 1'b1);             // ignored during dispense
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);             // open must still be low after this
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule